// File: doc/BRIEF.md
# Slow-Domain Register Write Bridge

This block carries register writes issued on a fast core clock into a bank of registers clocked by a slow timekeeping clock that runs about a thousand times slower. The fast side presents a one-cycle write with a target select and a data word. The bridge keeps the data in a per-target holding register and hands it across with a toggle handshake. The slow side loads the value into that target's register and returns an acknowledge toggle. Each target has its own channel, so writes to different targets can be in flight at the same time.

Software learns that a write has landed by polling a per-target busy bit in the fast domain. An aggregate bit reports whether any write is still in flight. A write aimed at a target that is still busy is discarded and raises a sticky error flag. The slow side also gives a one-cycle load strobe per target, which the logic that owns each register (counters, alarm comparators, interrupt clears) can use as its write event.

Top module: `wrb_bridge`

## Requirements
- R1: While the fast and slow resets are low, and right after they are released, every busy bit, the aggregate bit and the error flag read 0. Every slow register reads 0 and no load strobe is asserted.
- R2: A write with `wr_en_i`=1 and a select below the target count, to a target that is not busy, is accepted on that fast edge. The target's busy bit reads 1 from that edge on. Select codes are 0 control, 1 second alarm, 2 sub-second alarm, 3 counter load, 4 second interrupt clear, 5 sub-second interrupt clear.
- R3: A busy bit stays 1 until the slow side's acknowledge has come back through the fast synchronizer. Once it reads 0 again, slow register `s_reg_o[i*DATA_W +: DATA_W]` holds the accepted data.
- R4: Each accepted write produces exactly one load strobe on `s_wstb_o[i]`, lasting one slow cycle.
- R5: `any_busy_o` reads 1 exactly when at least one per-target busy bit reads 1.
- R6: A write to a target whose busy bit is 1 is discarded. It does not change the value that lands, it adds no strobe, and it sets `wr_err_o`.
- R7: `wr_err_o`, once set, stays 1 until reset.
- R8: Writes to different targets accepted on consecutive fast cycles are outstanding together, and each lands with its own data.
- R9: A write with a select code of the target count or above (codes 6 and 7) sets no busy bit, produces no strobe and does not set the error flag.
- R10: The data that lands is the value on `wr_data_i` at the accept edge. Later changes on `wr_data_i` while busy have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fclk_i | input | 1 | Fast core clock |
| frst_n_i | input | 1 | Fast-domain asynchronous active-low reset |
| sclk_i | input | 1 | Slow register clock |
| srst_n_i | input | 1 | Slow-domain asynchronous active-low reset |
| wr_en_i | input | 1 | One-cycle write request, fast domain |
| wr_sel_i | input | SEL_W | Target select code |
| wr_data_i | input | DATA_W | Write data |
| busy_o | output | NUM_TGT | Per-target write-in-flight bits, fast domain |
| any_busy_o | output | 1 | OR of all busy bits |
| wr_err_o | output | 1 | Sticky flag: a write to a busy target was dropped |
| s_wstb_o | output | NUM_TGT | Per-target one-cycle load strobe, slow domain |
| s_reg_o | output | NUM_TGT*DATA_W | Slow-domain registers, target i at bits i*DATA_W upward |

## Verification
The bench writes a second value to a target while its first write is still in flight. A bridge that let it through would toggle the request twice, so the strobe count and the landed value would be wrong. It also changes the data bus right after a write is accepted; a bridge that sampled the bus late, or did not hold it, would land the wrong word. Two targets are written on back-to-back cycles to catch a shared handshake that lets one write stall or overwrite the other. Out-of-range select codes are driven to catch a decoder that wraps them onto a real target.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int TGT_COUNT = 6;

  typedef enum logic [2:0] {
    TGT_CTRL     = 3'd0,
    TGT_SEC_ALM  = 3'd1,
    TGT_SUB_ALM  = 3'd2,
    TGT_CNT_LOAD = 3'd3,
    TGT_CLR_SEC  = 3'd4,
    TGT_CLR_SUB  = 3'd5
  } wrb_tgt_e;
endpackage

// File: rtl/wrb_sync2.sv
module wrb_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/wrb_fast_chan.sv
module wrb_fast_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_tgl_i,
  output logic              req_tgl_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              busy_o,
  output logic              drop_o
);
  logic              req_q, req_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              ack_s;
  logic              accept;

  wrb_sync2 u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (ack_tgl_i),
    .q_o  (ack_s)
  );

  assign busy_o = req_q ^ ack_s;

  always_comb begin
    accept = hit_i & ~busy_o;
    drop_o = hit_i & busy_o;
    req_d  = req_q ^ accept;
    hold_d = accept ? data_i : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      req_q <= req_d;
      if (accept) begin
        hold_q <= hold_d;
      end
    end
  end

  assign req_tgl_o = req_q;
  assign hold_o    = hold_q;

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(hold_q));

  // R6
  drop_no_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> $stable(req_q));
endmodule

// File: rtl/wrb_slow_chan.sv
module wrb_slow_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              stb_o,
  output logic [DATA_W-1:0] reg_o,
  output logic              ack_tgl_o
);
  logic              req_s;
  logic              ack_q, ack_d;
  logic [DATA_W-1:0] reg_q, reg_d;

  wrb_sync2 u_req_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (req_tgl_i),
    .q_o  (req_s)
  );

  always_comb begin
    stb_o = req_s ^ ack_q;
    ack_d = req_s;
    reg_d = stb_o ? hold_i : reg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      reg_q <= '0;
    end else begin
      ack_q <= ack_d;
      if (stb_o) begin
        reg_q <= reg_d;
      end
    end
  end

  assign reg_o     = reg_q;
  assign ack_tgl_o = ack_q;

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> !stb_o);

  // R3
  strobe_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> (reg_o == $past(hold_i)));
endmodule

// File: rtl/wrb_bridge.sv
module wrb_bridge #(
  parameter int DATA_W  = 32,
  parameter int NUM_TGT = wrb_pkg::TGT_COUNT,
  localparam int SEL_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic                      fclk_i,
  input  logic                      frst_n_i,
  input  logic                      sclk_i,
  input  logic                      srst_n_i,
  input  logic                      wr_en_i,
  input  logic [SEL_W-1:0]          wr_sel_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  output logic [NUM_TGT-1:0]        busy_o,
  output logic                      any_busy_o,
  output logic                      wr_err_o,
  output logic [NUM_TGT-1:0]        s_wstb_o,
  output logic [NUM_TGT*DATA_W-1:0] s_reg_o
);
  logic               frst_n, srst_n;
  logic [NUM_TGT-1:0] hit, drop, req_tgl, ack_tgl;
  logic [DATA_W-1:0]  hold [NUM_TGT];
  logic               sel_ok;
  logic               err_q, err_d;

  // reset: asserted asynchronously, released on the local clock
  wrb_sync2 u_frst (
    .clk  (fclk_i),
    .rst_n(frst_n_i),
    .d_i  (1'b1),
    .q_o  (frst_n)
  );

  wrb_sync2 u_srst (
    .clk  (sclk_i),
    .rst_n(srst_n_i),
    .d_i  (1'b1),
    .q_o  (srst_n)
  );

  assign sel_ok = (32'(wr_sel_i) < NUM_TGT);

  genvar g;
  generate
    for (g = 0; g < NUM_TGT; g++) begin : g_chan
      assign hit[g] = wr_en_i & sel_ok & (32'(wr_sel_i) == g);

      wrb_fast_chan #(.DATA_W(DATA_W)) u_fast (
        .clk      (fclk_i),
        .rst_n    (frst_n),
        .hit_i    (hit[g]),
        .data_i   (wr_data_i),
        .ack_tgl_i(ack_tgl[g]),
        .req_tgl_o(req_tgl[g]),
        .hold_o   (hold[g]),
        .busy_o   (busy_o[g]),
        .drop_o   (drop[g])
      );

      wrb_slow_chan #(.DATA_W(DATA_W)) u_slow (
        .clk      (sclk_i),
        .rst_n    (srst_n),
        .req_tgl_i(req_tgl[g]),
        .hold_i   (hold[g]),
        .stb_o    (s_wstb_o[g]),
        .reg_o    (s_reg_o[g*DATA_W +: DATA_W]),
        .ack_tgl_o(ack_tgl[g])
      );
    end
  endgenerate

  always_comb begin
    any_busy_o = |busy_o;
    err_d      = err_q | (|drop);
  end

  always_ff @(posedge fclk_i or negedge frst_n) begin
    if (!frst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign wr_err_o = err_q;

  // R7
  err_sticky_chk: assert property (@(posedge fclk_i) disable iff (!frst_n)
    wr_err_o |=> wr_err_o);

  // R9
  bad_sel_idle_chk: assert property (@(posedge fclk_i) disable iff (!frst_n)
    (wr_en_i && !sel_ok && !any_busy_o) |=> (!any_busy_o && $stable(wr_err_o)));

  // R5
  any_busy_match_chk: assert property (@(posedge fclk_i) disable iff (!frst_n)
    $rose(busy_o[0]) |-> any_busy_o);
endmodule

// File: tb/wrb_bridge_tb.sv
module wrb_bridge_tb_top;
  import wrb_pkg::*;

  localparam int CLK_PERIOD  = 10;
  localparam int SLOW_PERIOD = CLK_PERIOD * 17;
  localparam int DW          = 32;
  localparam int NT          = TGT_COUNT;
  localparam int SW          = 3;
  localparam int LAND_WAIT   = 400;
  localparam int WDOG_CYC    = 150000;

  logic                fclk = 1'b0;
  logic                sclk = 1'b0;
  logic                frst_n, srst_n;
  logic                wr_en;
  logic [SW-1:0]       wr_sel;
  logic [DW-1:0]       wr_data;
  logic [NT-1:0]       busy;
  logic                any_busy, wr_err;
  logic [NT-1:0]       s_wstb;
  logic [NT*DW-1:0]    s_reg;

  int checks = 0;
  int fails  = 0;
  int stb_cnt [NT];

  always #(CLK_PERIOD/2)  fclk = ~fclk;
  always #(SLOW_PERIOD/2) sclk = ~sclk;

  wrb_bridge #(.DATA_W(DW), .NUM_TGT(NT)) dut_i (
    .fclk_i    (fclk),
    .frst_n_i  (frst_n),
    .sclk_i    (sclk),
    .srst_n_i  (srst_n),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .busy_o    (busy),
    .any_busy_o(any_busy),
    .wr_err_o  (wr_err),
    .s_wstb_o  (s_wstb),
    .s_reg_o   (s_reg)
  );

  always @(posedge sclk) begin
    for (int i = 0; i < NT; i++) begin
      if (!srst_n) stb_cnt[i] <= 0;
      else if (s_wstb[i]) stb_cnt[i] <= stb_cnt[i] + 1;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] reg_of(input int t);
    return s_reg[t*DW +: DW];
  endfunction

  task automatic apply_reset();
    frst_n = 1'b0; srst_n = 1'b0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (3) @(posedge sclk);
    frst_n = 1'b1; srst_n = 1'b1;
    repeat (4) @(posedge sclk);
    @(negedge fclk);
  endtask

  task automatic write(input int sel, input logic [DW-1:0] d);
    @(negedge fclk);
    wr_en = 1'b1; wr_sel = SW'(sel); wr_data = d;
    @(negedge fclk);
    wr_en = 1'b0; wr_data = ~d;
  endtask

  task automatic wait_idle(input int t, input string req);
    int n = 0;
    while (busy[t] && n < LAND_WAIT) begin
      @(negedge fclk);
      n++;
    end
    check(req, "busy clears", busy[t], 0);
  endtask

  task automatic t_reset_state();
    apply_reset();
    check("R1", "busy", busy, 0);
    check("R1", "any_busy", any_busy, 0);
    check("R1", "err", wr_err, 0);
    check("R1", "strobes", s_wstb, 0);
    check("R1", "slow regs", s_reg == '0, 1);
  endtask

  task automatic t_single(input int t, input logic [DW-1:0] d);
    int c0 = stb_cnt[t];
    write(t, d);
    check("R2", "busy after accept", busy[t], 1);
    check("R5", "any_busy while in flight", any_busy, 1);
    wait_idle(t, "R3");
    check("R3", "landed data", reg_of(t), d);
    check("R10", "data held despite bus change", reg_of(t) != ~d, 1);
    check("R5", "any_busy idle", any_busy, 0);
    repeat (3) @(posedge sclk);
    @(negedge fclk);
    check("R4", "one strobe", stb_cnt[t] - c0, 1);
  endtask

  task automatic t_bad_sel();
    int c0 [NT];
    for (int i = 0; i < NT; i++) c0[i] = stb_cnt[i];
    write(6, 32'hDEAD_0006);
    check("R9", "no busy for code 6", any_busy, 0);
    write(7, 32'hDEAD_0007);
    check("R9", "no busy for code 7", any_busy, 0);
    repeat (5) @(posedge sclk);
    @(negedge fclk);
    check("R9", "no error", wr_err, 0);
    for (int i = 0; i < NT; i++) check("R9", "no strobe", stb_cnt[i] - c0[i], 0);
  endtask

  task automatic t_drop();
    int t = int'(TGT_SEC_ALM);
    int c0 = stb_cnt[t];
    write(t, 32'h1111_2222);
    write(t, 32'h3333_4444);
    check("R6", "error raised", wr_err, 1);
    wait_idle(t, "R6");
    check("R6", "first value kept", reg_of(t), 32'h1111_2222);
    repeat (4) @(posedge sclk);
    @(negedge fclk);
    check("R6", "single strobe", stb_cnt[t] - c0, 1);
    check("R7", "error sticky", wr_err, 1);
  endtask

  task automatic t_parallel();
    int a = int'(TGT_SUB_ALM);
    int b = int'(TGT_CNT_LOAD);
    write(a, 32'hAAAA_0001);
    write(b, 32'hBBBB_0002);
    check("R8", "both busy", {busy[a], busy[b]}, 2'b11);
    wait_idle(a, "R8");
    wait_idle(b, "R8");
    check("R8", "first target data", reg_of(a), 32'hAAAA_0001);
    check("R8", "second target data", reg_of(b), 32'hBBBB_0002);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge fclk);
    checks++; fails++;
    $display("FAIL watchdog (R3): actual=running expected=done");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_single(int'(TGT_CTRL),     32'h0000_00A5);
    t_single(int'(TGT_CLR_SEC),  32'h0000_0001);
    t_single(int'(TGT_CLR_SUB),  32'h8000_0001);
    t_bad_sel();
    t_drop();
    t_parallel();
    t_single(int'(TGT_CTRL),     32'h5A5A_F00F);
    check("R7", "still set before reset", wr_err, 1);
    apply_reset();
    check("R7", "cleared by reset", wr_err, 0);
    check("R1", "regs cleared", s_reg == '0, 1);
    finish_run();
  end
endmodule